// File: doc/BRIEF.md
# Eight-Pin I/O Port with Peripheral Direction Override

This block is one slice of general-purpose I/O. Software sees a direction register, an output data register and a read-only view of the synchronized pad inputs over a small register bus. For each pad the block chooses who drives the output enable and the output value. An enabled SPI module owns the pads it is wired to. Otherwise an enabled PWM channel owns its own pad. When neither claims a pad, the direction and data registers drive it.

A PWM channel always turns its pad into an output, with one exception. The channel on the shutdown pin instead releases its pad to input while the shutdown control is asserted, so the pad can be sensed. Pad inputs pass through a two-flop synchronizer before software can read them. Because of this, a read that follows a change of direction or of pad level shows the new value two clock edges later.

Register writes are always stored, even while a peripheral owns the pad. A stored value takes effect as soon as the peripheral lets go of the pad.

Top module: `gpio_ovr_port`

## Requirements
- R1: While reset is asserted, the direction and data registers read 0, and every pad output enable is 0 when no peripheral is enabled.
- R2: Register address 1 is the direction register. It can be written and read at any time. Bit i set to 1 makes pad i an output and 0 makes it an input.
- R3: When no peripheral claims pad i, pad_oe[i] equals direction bit i and pad_do[i] equals data bit i.
- R4: When pwm_en[i] is 1 and the SPI does not claim pad i, pad_oe[i] is 1 and pad_do[i] equals pwm_out[i]. Pad 7 is the exception described in R5.
- R5: When pwm_en[7] and pwm_shut_en are both 1 and the SPI does not claim pad 7, pad_oe[7] is 0 and pad_do[7] is 0.
- R6: When spi_en is 1, pads 7 to 4 follow spi_dir and spi_out on pad_oe and pad_do. This takes priority over both PWM and the registers.
- R7: Writes to the direction or data register made while a peripheral owns the pad are stored. They drive the pad from the first cycle after the peripheral is disabled.
- R8: Register address 2 returns pad_di as it was sampled two rising clock edges earlier. After reset it reads 0.
- R9: Register address 0 is the data register, written directly. On a read, bit i returns the data latch if direction bit i is 1, and the synchronized pad input if it is 0.
- R10: A write with bus_sel low, or to address 2 or 3, changes no register. A read of address 3, or any read with bus_sel low, returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address (0 data, 1 direction, 2 pad input) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| pwm_en | input | 8 | Per-channel PWM enable |
| pwm_out | input | 8 | Per-channel PWM waveform |
| pwm_shut_en | input | 1 | Shutdown control for PWM channel 7 |
| spi_en | input | 1 | SPI module enable |
| spi_dir | input | 8 | SPI requested output enable per pad |
| spi_out | input | 8 | SPI output value per pad |
| pad_di | input | 8 | Pad input levels |
| pad_oe | output | 8 | Pad output enable |
| pad_do | output | 8 | Pad output value |

## Verification
A register write and a change of pad ownership can land in the same cycle. The case at issue is a write to the direction or data register during the very cycle in which spi_en or pwm_en drops. The bench provokes this on purpose, and random stimulus also toggles enables and issues writes in the same cycles. The bench judges the result by predicting the pad outputs in the following cycle from a model of the stored register value, and the released pad must show the newly written value at once. A second overlap comes from changing pad_di and the direction bits together. Reads of addresses 0 and 2 are compared against a two-deep bench history of pad_di.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;

  localparam int ADDR_W = 2;

  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_DIR  = 2'd1,
    REG_PIN  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    OWN_REG,
    OWN_PWM,
    OWN_PWM_SHUT,
    OWN_SPI
  } owner_e;

  typedef struct packed {
    logic oe;
    logic dout;
  } pin_drive_t;

  // SPI claim beats PWM, and PWM beats the registers.
  function automatic owner_e pick_owner(logic spi_claim, logic pwm_on, logic shut_here);
    if (spi_claim)             return OWN_SPI;
    else if (pwm_on && shut_here) return OWN_PWM_SHUT;
    else if (pwm_on)           return OWN_PWM;
    else                       return OWN_REG;
  endfunction

  function automatic pin_drive_t drive_of(owner_e own, logic spi_oe, logic spi_val,
                                          logic pwm_val, logic dir_bit, logic dat_bit);
    pin_drive_t d;
    unique case (own)
      OWN_SPI:      begin d.oe = spi_oe;  d.dout = spi_val; end
      OWN_PWM:      begin d.oe = 1'b1;    d.dout = pwm_val; end
      OWN_PWM_SHUT: begin d.oe = 1'b0;    d.dout = 1'b0;    end
      default:      begin d.oe = dir_bit; d.dout = dat_bit; end
    endcase
    return d;
  endfunction

  // Data register read view: latch for outputs, synchronized pad for inputs.
  function automatic logic read_bit(logic dir_bit, logic latch, logic synced);
    return dir_bit ? latch : synced;
  endfunction

endpackage

// File: rtl/gpio_ovr_regs.sv
module gpio_ovr_regs
  import gpio_ovr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  input  logic [WIDTH-1:0]  pin_sync,
  output logic [WIDTH-1:0]  bus_rdata,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  dat_q
);

  logic wr_dir, wr_dat, rd_en;
  logic [WIDTH-1:0] dat_view;

  assign wr_dir = bus_sel && bus_wr && (bus_addr == REG_DIR);
  assign wr_dat = bus_sel && bus_wr && (bus_addr == REG_DATA);
  assign rd_en  = bus_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      dat_q <= '0;
    end else begin
      if (wr_dir) dir_q <= bus_wdata;
      if (wr_dat) dat_q <= bus_wdata;
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_view
    assign dat_view[i] = read_bit(dir_q[i], dat_q[i], pin_sync[i]);
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      unique case (reg_sel_e'(bus_addr))
        REG_DATA: bus_rdata = dat_view;
        REG_DIR:  bus_rdata = dir_q;
        REG_PIN:  bus_rdata = pin_sync;
        default:  bus_rdata = '0;
      endcase
    end
  end

  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> dir_q == $past(bus_wdata));

  // R10
  no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr) |=> $stable(dir_q) && $stable(dat_q));

  // R10
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_sel || bus_addr == REG_NONE) |-> bus_rdata == '0);

  // R9
  data_read_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_addr == REG_DATA) |-> (bus_rdata & dir_q) == (dat_q & dir_q));

endmodule

// File: rtl/gpio_ovr_sync.sv
module gpio_ovr_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pad_di,
  output logic [WIDTH-1:0] pin_sync
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
    end else begin
      stage_q[0] <= pad_di;
      for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
    end
  end

  assign pin_sync = stage_q[STAGES-1];

  if (STAGES == 2) begin : g_chk2
    logic [1:0] warm_q;
    logic       sync_warm;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             warm_q <= '0;
      else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end
    assign sync_warm = (warm_q == 2'd2);

    // R8
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sync_warm |-> pin_sync == $past(pad_di, 2));
  end

endmodule

// File: rtl/gpio_ovr_mux.sv
module gpio_ovr_mux
  import gpio_ovr_pkg::*;
#(
  parameter int               WIDTH    = 8,
  parameter logic [WIDTH-1:0] SPI_MASK = 8'hF0,
  parameter int               SHUT_CH  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pwm_en,
  input  logic [WIDTH-1:0] pwm_out,
  input  logic             pwm_shut_en,
  input  logic             spi_en,
  input  logic [WIDTH-1:0] spi_dir,
  input  logic [WIDTH-1:0] spi_out,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] dat_q,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_do
);

  logic [WIDTH-1:0] spi_claim;
  logic [WIDTH-1:0] pwm_claim;
  logic [WIDTH-1:0] shut_claim;

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    owner_e     own;
    pin_drive_t drv;
    logic       shut_here;

    assign shut_here     = (i == SHUT_CH) ? pwm_shut_en : 1'b0;
    assign spi_claim[i]  = spi_en && SPI_MASK[i];
    assign pwm_claim[i]  = pwm_en[i] && !spi_claim[i];
    assign shut_claim[i] = pwm_claim[i] && shut_here;
    assign own           = pick_owner(spi_claim[i], pwm_en[i], shut_here);
    assign drv           = drive_of(own, spi_dir[i], spi_out[i], pwm_out[i], dir_q[i], dat_q[i]);
    assign pad_oe[i]     = drv.oe;
    assign pad_do[i]     = drv.dout;

    // R6
    spi_owns_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spi_claim[i] |-> (pad_oe[i] == spi_dir[i]) && (pad_do[i] == spi_out[i]));

    // R4
    pwm_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_claim[i] && !shut_claim[i]) |-> pad_oe[i] && (pad_do[i] == pwm_out[i]));

    // R5
    pwm_shut_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shut_claim[i] |-> !pad_oe[i] && !pad_do[i]);

    // R3
    reg_owns_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!spi_claim[i] && !pwm_en[i]) |-> (pad_oe[i] == dir_q[i]) && (pad_do[i] == dat_q[i]));
  end

endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port
  import gpio_ovr_pkg::*;
#(
  parameter int               WIDTH       = 8,
  parameter int               SYNC_STAGES = 2,
  parameter logic [WIDTH-1:0] SPI_MASK    = 8'hF0,
  parameter int               SHUT_CH     = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pwm_en,
  input  logic [WIDTH-1:0]  pwm_out,
  input  logic              pwm_shut_en,
  input  logic              spi_en,
  input  logic [WIDTH-1:0]  spi_dir,
  input  logic [WIDTH-1:0]  spi_out,
  input  logic [WIDTH-1:0]  pad_di,
  output logic [WIDTH-1:0]  pad_oe,
  output logic [WIDTH-1:0]  pad_do
);

  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] dat_q;

  gpio_ovr_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pad_di(pad_di), .pin_sync(pin_sync)
  );

  gpio_ovr_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pin_sync(pin_sync),
    .bus_rdata(bus_rdata), .dir_q(dir_q), .dat_q(dat_q)
  );

  gpio_ovr_mux #(.WIDTH(WIDTH), .SPI_MASK(SPI_MASK), .SHUT_CH(SHUT_CH)) u_mux (
    .clk(clk), .rst_n(rst_n), .pwm_en(pwm_en), .pwm_out(pwm_out),
    .pwm_shut_en(pwm_shut_en), .spi_en(spi_en), .spi_dir(spi_dir),
    .spi_out(spi_out), .dir_q(dir_q), .dat_q(dat_q),
    .pad_oe(pad_oe), .pad_do(pad_do)
  );

  // R7: a stored direction bit reaches the pad on the first cycle the SPI lets go
  release_takes_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(spi_en) && (pwm_en == '0)) |-> pad_oe == dir_q);

endmodule

// File: tb/gpio_ovr_port_bench.sv
`timescale 1ns/1ps
module gpio_ovr_port_bench;
  localparam int         W        = 8;
  localparam logic [7:0] SPI_MASK = 8'hF0;
  localparam int         SHUT     = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 0, bus_wr = 0;
  logic [1:0] bus_addr = 0;
  logic [W-1:0] bus_wdata = 0, bus_rdata;
  logic [W-1:0] pwm_en = 0, pwm_out = 0, spi_dir = 0, spi_out = 0, pad_di = 0;
  logic pwm_shut_en = 0, spi_en = 0;
  logic [W-1:0] pad_oe, pad_do;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [W-1:0] dir_m = 0, dat_m = 0, s1 = 0, s2 = 0;

  always #2.5 clk = ~clk;

  gpio_ovr_port u_gpio_ovr_port (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_en(pwm_en), .pwm_out(pwm_out), .pwm_shut_en(pwm_shut_en),
    .spi_en(spi_en), .spi_dir(spi_dir), .spi_out(spi_out),
    .pad_di(pad_di), .pad_oe(pad_oe), .pad_do(pad_do)
  );

  // Expected pad drive: SPI on pads 7..4, then PWM (pad 7 released by shutdown), then registers
  function automatic logic [15:0] exp_pads();
    logic [W-1:0] oe, dq;
    for (int b = 0; b < W; b++) begin
      if (spi_en && SPI_MASK[b]) begin oe[b] = spi_dir[b]; dq[b] = spi_out[b]; end
      else if (pwm_en[b] && b == SHUT && pwm_shut_en) begin oe[b] = 0; dq[b] = 0; end
      else if (pwm_en[b]) begin oe[b] = 1; dq[b] = pwm_out[b]; end
      else begin oe[b] = dir_m[b]; dq[b] = dat_m[b]; end
    end
    return {oe, dq};
  endfunction

  function automatic logic [W-1:0] exp_read();
    if (!bus_sel) return '0;
    case (bus_addr)
      2'd0: return (dat_m & dir_m) | (s2 & ~dir_m);
      2'd1: return dir_m;
      2'd2: return s2;
      default: return '0;
    endcase
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Check current outputs, then take one clock edge and update the model
  task automatic tick(string tag);
    logic [15:0] e;
    #1;
    e = exp_pads();
    chk({tag, " pad_oe"}, pad_oe, e[15:8]);
    chk({tag, " pad_do"}, pad_do, e[7:0]);
    chk({tag, " rdata"}, bus_rdata, exp_read());
    @(posedge clk);
    if (bus_sel && bus_wr && bus_addr == 2'd0) dat_m = bus_wdata;
    if (bus_sel && bus_wr && bus_addr == 2'd1) dir_m = bus_wdata;
    s2 = s1;
    s1 = pad_di;
    @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [W-1:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic rd(logic [1:0] a);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state
    repeat (3) @(negedge clk);
    rd(2'd1); #1;
    chk("R1 dir in reset", bus_rdata, 8'h00);
    chk("R1 oe in reset", pad_oe, 8'h00);
    rd(2'd0); pad_di = 8'h00; #1;
    chk("R1 data in reset", bus_rdata, 8'h00);
    @(negedge clk);
    rst_n = 1;
    tick("R1");

    // R2 / R3: direction write then read back, register-owned pads
    wr(2'd1, 8'hA5); tick("R2");
    wr(2'd0, 8'h3C); tick("R3");
    rd(2'd1); tick("R2");
    rd(2'd0); tick("R3");

    // R8: two-edge latency of pad input
    wr(2'd1, 8'h00); tick("R8");
    rd(2'd2); pad_di = 8'h00; tick("R8"); tick("R8");
    pad_di = 8'hFF; tick("R8");
    chk("R8 after one edge", bus_rdata, 8'h00); tick("R8");
    chk("R8 after two edges", bus_rdata, 8'hFF); tick("R8");

    // R9: mixed read of data register
    wr(2'd1, 8'h0F); tick("R9");
    wr(2'd0, 8'h33); pad_di = 8'hAA; tick("R9");
    rd(2'd0); tick("R9"); tick("R9");
    chk("R9 mixed read", bus_rdata, 8'hA3); tick("R9");

    // R4 / R5: PWM drive and pad 7 shutdown
    wr(2'd1, 8'h00); pwm_en = 8'h81; pwm_out = 8'h80; tick("R4");
    chk("R4 pwm oe", pad_oe, 8'h81); tick("R4");
    pwm_shut_en = 1; tick("R5");
    chk("R5 shut oe", pad_oe, 8'h01); tick("R5");
    pwm_shut_en = 0; pwm_en = 0;

    // R6: SPI beats PWM on pads 7..4
    spi_en = 1; pwm_en = 8'hFF; pwm_out = 8'hFF; spi_dir = 8'h5A; spi_out = 8'h00; tick("R6");
    chk("R6 spi priority oe", pad_oe, 8'h5F); tick("R6");
    pwm_en = 0;

    // R7: write while owned, same cycle as release
    wr(2'd1, 8'hC3); tick("R7");
    wr(2'd0, 8'hF0); spi_en = 0; tick("R7");
    rd(2'd1);
    chk("R7 released dir", pad_oe, 8'hC3); tick("R7");

    // R10: ignored writes and unmapped read
    bus_sel = 0; bus_wr = 1; bus_addr = 2'd1; bus_wdata = 8'h11; tick("R10");
    wr(2'd2, 8'h22); tick("R10");
    wr(2'd3, 8'h33); tick("R10");
    rd(2'd1); tick("R10");
    chk("R10 dir kept", bus_rdata, 8'hC3); tick("R10");
    rd(2'd3); tick("R10");

    // Random mix
    for (int n = 0; n < 600; n++) begin
      bus_sel   = 1'($urandom_range(0, 1));
      bus_wr    = 1'($urandom_range(0, 1));
      bus_addr  = 2'($urandom_range(0, 3));
      bus_wdata = 8'($urandom);
      pwm_en    = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00;
      pwm_out   = 8'($urandom);
      pwm_shut_en = 1'($urandom_range(0, 1));
      spi_en    = ($urandom_range(0, 3) == 0);
      spi_dir   = 8'($urandom);
      spi_out   = 8'($urandom);
      if ($urandom_range(0, 2) == 0) pad_di = 8'($urandom);
      tick("R3 R4 R5 R6 R7 R8 R9 random");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule